// File: doc/BRIEF.md
# Whitened LFSR Challenge Scrambler

This block expands one challenge word into a stream of select values, one per response bit of a ring-oscillator response generator. On a load strobe it captures the challenge twice: once as the starting state of a maximal-length linear feedback shift register, and once in a whitening register that stays fixed for the rest of the response. Each shift strobe advances the register by one step. The select output is always the running register state XORed with the stored challenge.

The XOR with the stored challenge matters when two challenges sit next to each other in the register's cycle. Without it, the two select streams would be the same sequence offset by one step. With it, every position of the two streams differs. The select word is split into two equal fields, and each field addresses one bank of oscillators. The upper field drives bank A and the lower field drives bank B.

An all-zero running state would lock the register, so a zero challenge starts the register at one while the whitening register still holds zero. The reset input is asserted asynchronously and released synchronously inside the block.

Top module: `chal_scrambler`

## Requirements
- R1: After reset, and until the first load, the running state is 1 and the whitening value is 0, so sel_o reads 10'h001 (bank A field 0, bank B field 1).
- R2: A cycle with load_i high and a nonzero chal_i stores chal_i as both the running state and the whitening value. From the next cycle sel_o reads 0.
- R3: A cycle with shift_i high and load_i low moves the running state one place toward the MSB and puts state[9] XOR state[6] into bit 0. The whitening value is unchanged, and sel_o shows the new state XOR the whitening value.
- R4: A cycle with load_i and shift_i both low leaves sel_o unchanged.
- R5: Loading chal_i = 0 sets the running state to 1 and the whitening value to 0, so sel_o reads 10'h001.
- R6: When load_i and shift_i are high in the same cycle, the load takes effect and no shift occurs.
- R7: sel_bank_a_o equals sel_o[9:5] and sel_bank_b_o equals sel_o[4:0].
- R8: The running state is never zero. Starting from any nonzero state, it first returns to that state after exactly 1023 shifts.
- R9: Let challenge Y be one shift step after challenge X. For k >= 0, select value k+1 of X never equals select value k of Y.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| chal_i | input | 10 | Initial challenge word |
| load_i | input | 1 | Capture chal_i as the new starting state and whitening value |
| shift_i | input | 1 | Advance the running state by one step |
| sel_o | output | 10 | Whitened select value |
| sel_bank_a_o | output | 5 | Oscillator select for bank A (upper field) |
| sel_bank_b_o | output | 5 | Oscillator select for bank B (lower field) |

## Verification
A wrong feedback tap or a wrong shift direction changes sel_o on the first shift after a load. The check therefore compares every select value against a reference stepper, one cycle after each strobe. A whitening register that is wrongly captured or changes during a response shows up on the cycle right after the load, because sel_o must then read zero. A broken zero guard shows up the same way, because sel_o must then read one. Faults that only shorten the register's cycle appear only over a full period, so the bench also counts shifts until the state returns to its start.

// File: rtl/chal_scrambler_pkg.sv
package chal_scrambler_pkg;
  localparam int unsigned SEL_W   = 10;
  localparam int unsigned FIELD_W = SEL_W / 2;
  // x^10 + x^7 + 1 : feedback from bits 9 and 6
  localparam logic [SEL_W-1:0] TAP_MASK = 10'b10_0100_0000;

  typedef logic [SEL_W-1:0] sel_t;
endpackage

// File: rtl/scr_rst_sync.sv
module scr_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/scr_lfsr_core.sv
module scr_lfsr_core #(
  parameter int unsigned     W    = 10,
  parameter logic [W-1:0]    TAPS = 10'b10_0100_0000
) (
  input  logic         clk,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic         shift_i,
  input  logic [W-1:0] seed_i,
  output logic [W-1:0] state_o
);
  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  logic [W-1:0] state_q, state_d;
  logic         en;
  logic         fb;

  assign fb = ^(state_q & TAPS);
  assign en = load_i | shift_i;

  always_comb begin
    state_d = state_q;
    if (load_i) begin
      state_d = (seed_i == '0) ? ONE : seed_i;
    end else if (shift_i) begin
      state_d = {state_q[W-2:0], fb};
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni)  state_q <= ONE;
    else if (en)  state_q <= state_d;
  end

  assign state_o = state_q;

  assert_state_nonzero_R8: assert property (@(posedge clk) disable iff (!rst_ni)
    state_q != '0);
  assert_load_nonzero_R2: assert property (@(posedge clk) disable iff (!rst_ni)
    (load_i && seed_i != '0) |=> state_q == $past(seed_i));
  assert_load_zero_R5: assert property (@(posedge clk) disable iff (!rst_ni)
    (load_i && seed_i == '0) |=> state_q == ONE);
  assert_shift_moves_R3: assert property (@(posedge clk) disable iff (!rst_ni)
    (shift_i && !load_i) |=> state_q[W-1:1] == $past(state_q[W-2:0]));
endmodule

// File: rtl/scr_whiten_reg.sv
module scr_whiten_reg #(
  parameter int unsigned W = 10
) (
  input  logic         clk,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] chal_i,
  output logic [W-1:0] mask_o
);
  logic [W-1:0] mask_q, mask_d;

  always_comb begin
    mask_d = mask_q;
    if (load_i) mask_d = chal_i;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni)     mask_q <= '0;
    else if (load_i) mask_q <= mask_d;
  end

  assign mask_o = mask_q;

  assert_mask_capture_R2: assert property (@(posedge clk) disable iff (!rst_ni)
    load_i |=> mask_q == $past(chal_i));
  assert_mask_hold_R3: assert property (@(posedge clk) disable iff (!rst_ni)
    !load_i |=> $stable(mask_q));
endmodule

// File: rtl/scr_sel_split.sv
module scr_sel_split #(
  parameter int unsigned W = 10
) (
  input  logic [W-1:0]   state_i,
  input  logic [W-1:0]   mask_i,
  output logic [W-1:0]   sel_o,
  output logic [W/2-1:0] hi_o,
  output logic [W/2-1:0] lo_o
);
  localparam int unsigned HW = W / 2;

  for (genvar b = 0; b < W; b++) begin : g_xor
    assign sel_o[b] = state_i[b] ^ mask_i[b];
  end

  assign hi_o = sel_o[W-1:HW];
  assign lo_o = sel_o[HW-1:0];
endmodule

// File: rtl/chal_scrambler.sv
module chal_scrambler
  import chal_scrambler_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [SEL_W-1:0]   chal_i,
  input  logic               load_i,
  input  logic               shift_i,
  output logic [SEL_W-1:0]   sel_o,
  output logic [FIELD_W-1:0] sel_bank_a_o,
  output logic [FIELD_W-1:0] sel_bank_b_o
);
  logic rst_sync_n;
  sel_t state, mask;

  scr_rst_sync #(.STAGES(2)) i_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  scr_lfsr_core #(.W(SEL_W), .TAPS(TAP_MASK)) i_lfsr (
    .clk(clk), .rst_ni(rst_sync_n), .load_i(load_i), .shift_i(shift_i),
    .seed_i(chal_i), .state_o(state)
  );

  scr_whiten_reg #(.W(SEL_W)) i_mask (
    .clk(clk), .rst_ni(rst_sync_n), .load_i(load_i), .chal_i(chal_i),
    .mask_o(mask)
  );

  scr_sel_split #(.W(SEL_W)) i_split (
    .state_i(state), .mask_i(mask), .sel_o(sel_o),
    .hi_o(sel_bank_a_o), .lo_o(sel_bank_b_o)
  );

  assert_idle_hold_R4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!load_i && !shift_i) |=> $stable(sel_o));
  assert_load_zero_sel_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    load_i |=> (sel_o == '0 || sel_o == sel_t'(1)));
  assert_load_wins_R6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (load_i && shift_i && chal_i != '0) |=> sel_o == '0);
  assert_fields_R7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    {sel_bank_a_o, sel_bank_b_o} == sel_o);
endmodule

// File: tb/test_chal_scrambler.sv
`timescale 1ns/1ps
module test_chal_scrambler;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [9:0] chal_i = '0;
  logic       load_i = 1'b0;
  logic       shift_i = 1'b0;
  logic [9:0] sel_o;
  logic [4:0] sel_bank_a_o, sel_bank_b_o;

  int n_tests = 0;
  int n_fail  = 0;
  logic [9:0] m_st, m_wh;
  logic [9:0] seq_x [0:8];
  logic [9:0] seq_y [0:8];

  always #2.5 clk = ~clk;

  chal_scrambler i_chal_scrambler (
    .clk(clk), .rst_n(rst_n), .chal_i(chal_i), .load_i(load_i),
    .shift_i(shift_i), .sel_o(sel_o), .sel_bank_a_o(sel_bank_a_o),
    .sel_bank_b_o(sel_bank_b_o)
  );

  function automatic logic [9:0] f_step(input logic [9:0] s);
    return {s[8:0], s[9] ^ s[6]};
  endfunction

  task automatic check(input string req, input logic [9:0] act, input logic [9:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // drive at negedge, one posedge, back at negedge; update model
  task automatic cyc(input logic ld, input logic sh, input logic [9:0] c);
    load_i = ld; shift_i = sh; chal_i = c;
    @(posedge clk);
    if (ld) begin
      m_st = (c == '0) ? 10'd1 : c;
      m_wh = c;
    end else if (sh) begin
      m_st = f_step(m_st);
    end
    @(negedge clk);
    load_i = 1'b0; shift_i = 1'b0;
  endtask

  task automatic check_model(input string req);
    check(req, sel_o, m_st ^ m_wh);
    check({req, "_R7"}, {sel_bank_a_o, sel_bank_b_o}, sel_o);
  endtask

  initial begin
    #400000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    m_st = 10'd1; m_wh = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    check("R1 reset sel", sel_o, 10'h001);
    check("R1 bank a", {5'd0, sel_bank_a_o}, 10'd0);
    check("R1 bank b", {5'd0, sel_bank_b_o}, 10'd1);

    // R2 load nonzero
    cyc(1'b1, 1'b0, 10'h2B5);
    check("R2 sel after load", sel_o, 10'h000);
    // R3 shifts
    for (int i = 0; i < 12; i++) begin
      cyc(1'b0, 1'b1, '0);
      check_model("R3 shift");
    end
    // R4 idle hold, with chal_i toggling
    begin
      logic [9:0] held;
      held = sel_o;
      for (int i = 0; i < 4; i++) begin
        cyc(1'b0, 1'b0, 10'(i * 97 + 5));
        check("R4 idle hold", sel_o, held);
      end
    end
    // R5 zero challenge
    cyc(1'b1, 1'b0, 10'h000);
    check("R5 zero load", sel_o, 10'h001);
    cyc(1'b0, 1'b1, '0);
    check("R5 shift after zero", sel_o, 10'h002);
    // R6 load and shift together
    cyc(1'b1, 1'b1, 10'h155);
    check("R6 load priority", sel_o, 10'h000);
    cyc(1'b0, 1'b1, '0);
    check_model("R6 following shift");

    // R8 period from state 0x001 (load zero gives state 1, mask 0)
    cyc(1'b1, 1'b0, 10'h000);
    begin
      int steps = 0;
      logic zero_seen = 1'b0;
      do begin
        cyc(1'b0, 1'b1, '0);
        steps++;
        if (sel_o == '0) zero_seen = 1'b1;
      end while (sel_o != 10'h001 && steps < 1100);
      check("R8 period", 10'(steps), 10'd1023);
      check("R8 never zero", {9'd0, zero_seen}, 10'd0);
    end

    // R9 adjacent challenges
    begin
      logic [9:0] x, y;
      x = 10'h1C3; y = f_step(x);
      cyc(1'b1, 1'b0, x);
      for (int k = 0; k < 9; k++) begin cyc(1'b0, 1'b1, '0); seq_x[k] = sel_o; end
      cyc(1'b1, 1'b0, y);
      for (int k = 0; k < 9; k++) begin cyc(1'b0, 1'b1, '0); seq_y[k] = sel_o; end
      for (int k = 0; k < 8; k++) begin
        n_tests++;
        if (seq_x[k+1] == seq_y[k]) begin
          n_fail++;
          $display("FAIL R9 adjacent overlap k=%0d: actual %h expected not %h", k, seq_y[k], seq_x[k+1]);
        end
      end
    end

    // random mix
    for (int i = 0; i < 400; i++) begin
      int r;
      logic [9:0] c;
      r = $urandom_range(0, 9);
      c = (r == 9) ? 10'h000 : 10'($urandom);
      cyc(r < 2 || r == 9, r >= 2 && r < 8 || r == 1, c);
      check_model("R3 random");
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule